// File: doc/BRIEF.md
# Three-Wire Command Receiver with Digital Volume Stage

This block receives 8-bit command words from a host over three slow pins: a shift clock, a data line and a latch line. All three pins are brought into the core clock domain by synchronisers. The core clock then finds the edges of the shift clock and the latch line. Data bits are collected on shift-clock rising edges, lowest bit first. A rising edge on the latch line applies the collected word.

The top bit of a word chooses which register it writes. With the top bit clear, the low seven bits become the attenuation code. With the top bit set, two bits pick the de-emphasis mode, which is presented on an output for a neighbouring filter.

The attenuation code scales a pair of signed 16-bit audio samples, left and right, by the gain code/127. A single-cycle sample strobe loads the inputs, and the scaled results appear in registered outputs one cycle later.

Top module: `sctl_att_top`

## Requirements
- R1: A command word is 8 bits. The data pin is sampled on each rising edge of the shift clock while the latch line is low. The first bit shifted is D0 and the eighth is D7.
- R2: The registers change only when the latch line rises. The new value is visible on `attCode`/`emphMode` within 6 core clocks of the rise. Shifting bits without a latch rise leaves both registers unchanged.
- R3: A word applied with D7=0 loads D6..D0 into `attCode` and leaves `emphMode` unchanged. `attCode` and `emphMode` never change in the same cycle.
- R4: A word applied with D7=1 sets `emphMode` = {D6, D5}, with these codes: 0 = off, 1 = 44.1 kHz curve, 2 = 48 kHz curve, 3 = 32 kHz curve. D4..D0 are ignored, and `attCode` is unchanged.
- R5: After reset, `attCode` is 0x7F, `emphMode` is 0, `outValid` is 0, and both sample outputs are 0.
- R6: For codes 1 to 127, each output equals input × code / 127, truncated toward zero and saturated to the signed 16-bit range. Code 0x7F therefore passes the input unchanged. The magnitude of an output never exceeds the magnitude of its input.
- R7: Attenuation code 0 forces both outputs to 0.
- R8: The sample outputs load in the clock edge after the one that samples `sampleStb` high. `outValid` is high for exactly that cycle. With no strobe, the outputs hold their values.
- R9: Shift-clock rising edges that arrive while the latch line is high are ignored. They do not alter the word that the next latch rise applies.
- R10: The left and right channels use the same code, and each is scaled from its own input only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| shiftClkPin | input | 1 | Host shift clock (asynchronous) |
| latchPin | input | 1 | Host latch line (asynchronous) |
| dataPin | input | 1 | Host serial data (asynchronous) |
| sampleStb | input | 1 | One-cycle strobe that loads a sample pair |
| inLeft | input | 16 | Left sample, signed |
| inRight | input | 16 | Right sample, signed |
| outLeft | output | 16 | Scaled left sample, signed |
| outRight | output | 16 | Scaled right sample, signed |
| outValid | output | 1 | High for the cycle in which new outputs appear |
| attCode | output | 7 | Current attenuation code |
| emphMode | output | 2 | Current de-emphasis mode code |

## Verification
A wrong bit in the receive shift register, or a wrong word order, shows up on `attCode` or `emphMode` a few core clocks after the next latch rise. It appears as a code that differs from the word sent. A corrupted attenuation register, or a wrong scale, shows up on the very next strobed sample as an output that differs from the truncated product. It is most visible near full scale and at the codes 0, 1 and 127. Shift edges that leak through while the latch is high stay hidden until a later latch rise applies the stale word, so the stimulus adds a second latch rise with no new bits shifted.

// File: rtl/sctl_att_pkg.sv
package sctl_att_pkg;

  localparam int CMD_BITS = 8;
  localparam int ATT_W    = 7;
  localparam int MODE_W   = 2;
  localparam logic [ATT_W-1:0] ATT_RESET = '1;

  // Strobes and payload passed from the control path to the datapath
  typedef struct packed {
    logic              attLoad;
    logic [ATT_W-1:0]  attValue;
    logic              emphLoad;
    logic [MODE_W-1:0] emphValue;
  } ctl_cmd_t;

endpackage

// File: rtl/sctl_pin_sync.sv
module sctl_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign pinOut = stageQ[STAGES-1];

endmodule

// File: rtl/sctl_cmd_rx.sv
module sctl_cmd_rx
  import sctl_att_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftSync,
  input  logic              latchSync,
  input  logic              dataSync,
  output ctl_cmd_t          cmd,
  output logic [MODE_W-1:0] emphMode
);

  logic                shiftQ;
  logic                latchQ;
  logic [CMD_BITS-1:0] wordQ;
  logic                shiftRise;
  logic                latchRise;

  assign shiftRise = shiftSync & ~shiftQ;
  assign latchRise = latchSync & ~latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= 1'b0;
      latchQ <= 1'b0;
      wordQ  <= '0;
    end else begin
      shiftQ <= shiftSync;
      latchQ <= latchSync;
      // bits enter at the top; after eight edges the first bit sits at bit 0
      if (shiftRise && !latchSync) wordQ <= {dataSync, wordQ[CMD_BITS-1:1]};
    end
  end

  always_comb begin
    cmd.attLoad   = latchRise & ~wordQ[CMD_BITS-1];
    cmd.attValue  = wordQ[ATT_W-1:0];
    cmd.emphLoad  = latchRise & wordQ[CMD_BITS-1];
    cmd.emphValue = wordQ[CMD_BITS-2 -: MODE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             emphMode <= '0;
    else if (cmd.emphLoad) emphMode <= cmd.emphValue;
  end

endmodule

// File: rtl/sctl_att_path.sv
module sctl_att_path
  import sctl_att_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NUM_CH   = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctl_cmd_t                          cmd,
  input  logic                              sampleStb,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]   sampleIn,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]   sampleOut,
  output logic                              outValid,
  output logic [ATT_W-1:0]                  attCode
);

  localparam int PROD_W = SAMPLE_W + ATT_W + 1;
  localparam int UNITY  = (2 ** ATT_W) - 1;
  localparam int HI_I   = (2 ** (SAMPLE_W - 1)) - 1;
  localparam int LO_I   = -(2 ** (SAMPLE_W - 1));
  localparam logic signed [PROD_W-1:0] SAT_HI  = HI_I[PROD_W-1:0];
  localparam logic signed [PROD_W-1:0] SAT_LO  = LO_I[PROD_W-1:0];
  localparam logic signed [PROD_W-1:0] DIVISOR = UNITY[PROD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            attCode <= ATT_RESET;
    else if (cmd.attLoad) attCode <= cmd.attValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleStb;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   quot;
    logic signed [SAMPLE_W-1:0] scaled;
    logic [SAMPLE_W-1:0]        outQ;

    always_comb begin
      prod = PROD_W'($signed(sampleIn[c])) * $signed({{(PROD_W-ATT_W){1'b0}}, attCode});
      quot = prod / DIVISOR;   // signed division truncates toward zero
      if (attCode == '0)      scaled = '0;
      else if (quot > SAT_HI) scaled = SAT_HI[SAMPLE_W-1:0];
      else if (quot < SAT_LO) scaled = SAT_LO[SAMPLE_W-1:0];
      else                    scaled = quot[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          outQ <= '0;
      else if (sampleStb) outQ <= scaled;
    end

    assign sampleOut[c] = outQ;
  end

endmodule

// File: rtl/sctl_att_top.sv
module sctl_att_top
  import sctl_att_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftClkPin,
  input  logic        latchPin,
  input  logic        dataPin,
  input  logic        sampleStb,
  input  logic [15:0] inLeft,
  input  logic [15:0] inRight,
  output logic [15:0] outLeft,
  output logic [15:0] outRight,
  output logic        outValid,
  output logic [6:0]  attCode,
  output logic [1:0]  emphMode
);

  localparam int SAMPLE_W = 16;
  localparam int NUM_CH   = 2;

  logic [2:0]                          pinsSync;
  ctl_cmd_t                            cmd;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]     samplesIn;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]     samplesOut;

  sctl_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  ({shiftClkPin, latchPin, dataPin}),
    .pinOut (pinsSync)
  );

  sctl_cmd_rx rx_i (
    .clk       (clk),
    .rstN      (rstN),
    .shiftSync (pinsSync[2]),
    .latchSync (pinsSync[1]),
    .dataSync  (pinsSync[0]),
    .cmd       (cmd),
    .emphMode  (emphMode)
  );

  assign samplesIn = {inRight, inLeft};

  sctl_att_path #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .sampleStb (sampleStb),
    .sampleIn  (samplesIn),
    .sampleOut (samplesOut),
    .outValid  (outValid),
    .attCode   (attCode)
  );

  assign outLeft  = samplesOut[0];
  assign outRight = samplesOut[1];

endmodule

// File: rtl/sctl_att_chk.sv
module sctl_att_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleStb,
  input logic [15:0] inLeft,
  input logic [15:0] inRight,
  input logic [15:0] outLeft,
  input logic [15:0] outRight,
  input logic        outValid,
  input logic [6:0]  attCode,
  input logic [1:0]  emphMode
);

  function automatic logic [16:0] magOf(logic [15:0] v);
    logic signed [16:0] s;
    s = {v[15], v};
    return (s < 0) ? 17'(-s) : 17'(s);
  endfunction

  // R8: a valid pulse only follows a strobe
  p_valid_follows_stb_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleStb));

  // R8: outputs hold when no strobe was sampled
  p_hold_without_stb_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> ($stable(outLeft) && $stable(outRight)));

  // R7: a zero code mutes both channels
  p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(attCode) == 7'd0) |-> (outLeft == 16'd0 && outRight == 16'd0));

  // R6: unity code passes the sample through
  p_unity_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(attCode) == 7'h7F) |-> (outLeft == $past(inLeft) && outRight == $past(inRight)));

  // R6: attenuation never grows a sample
  p_no_gain_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (magOf(outLeft) <= magOf($past(inLeft)) && magOf(outRight) <= magOf($past(inRight))));

  // R3: one command word touches one register only
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(attCode)) |-> $stable(emphMode));

endmodule

bind sctl_att_top sctl_att_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sampleStb (sampleStb),
  .inLeft    (inLeft),
  .inRight   (inRight),
  .outLeft   (outLeft),
  .outRight  (outRight),
  .outValid  (outValid),
  .attCode   (attCode),
  .emphMode  (emphMode)
);

// File: tb/sctl_att_top_tb_top.sv
module sctl_att_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shiftClkPin = 1'b0;
  logic        latchPin = 1'b0;
  logic        dataPin = 1'b0;
  logic        sampleStb = 1'b0;
  logic [15:0] inLeft = '0;
  logic [15:0] inRight = '0;
  logic [15:0] outLeft;
  logic [15:0] outRight;
  logic        outValid;
  logic [6:0]  attCode;
  logic [1:0]  emphMode;

  int checks = 0;
  int failures = 0;
  int expCode = 127;
  int expL[$];
  int expR[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sctl_att_top dut_i (
    .clk(clk), .rstN(rstN), .shiftClkPin(shiftClkPin), .latchPin(latchPin),
    .dataPin(dataPin), .sampleStb(sampleStb), .inLeft(inLeft), .inRight(inRight),
    .outLeft(outLeft), .outRight(outRight), .outValid(outValid),
    .attCode(attCode), .emphMode(emphMode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      dataPin = w[i];
      waitClk(4);
      shiftClkPin = 1'b1;
      waitClk(4);
      shiftClkPin = 1'b0;
    end
    waitClk(4);
  endtask

  task automatic pulseLatch();
    latchPin = 1'b1;
    waitClk(8);
    latchPin = 1'b0;
    waitClk(8);
  endtask

  task automatic sendWord(input logic [7:0] w);
    shiftBits(w);
    pulseLatch();
    if (!w[7]) expCode = int'(w[6:0]);
  endtask

  function automatic int scaleOf(input int s, input int code);
    int q;
    q = (s * code) / 127;   // integer division truncates toward zero
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic pushSample(input int l, input int r);
    sampleStb = 1'b1;
    inLeft  = 16'(l);
    inRight = 16'(r);
    expL.push_back(scaleOf(l, expCode));
    expR.push_back(scaleOf(r, expCode));
    waitClk(1);
    sampleStb = 1'b0;
  endtask

  // Monitor: pops one expected pair for every valid pulse
  always @(negedge clk) begin
    if (rstN && outValid && !finished) begin
      if (expL.size() == 0) begin
        check(1'b0, "R8 unexpected valid", 1, 0);
      end else begin
        int el, er;
        el = expL.pop_front();
        er = expR.pop_front();
        check(int'($signed(outLeft)) == el, "R6/R10 left", int'($signed(outLeft)), el);
        check(int'($signed(outRight)) == er, "R6/R10 right", int'($signed(outRight)), er);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    waitClk(3);
    // R5: reset state
    check(attCode == 7'h7F, "R5 attCode", attCode, 127);
    check(emphMode == 2'd0, "R5 emphMode", emphMode, 0);
    check(outValid == 1'b0, "R5 outValid", outValid, 0);
    check(outLeft == 16'd0 && outRight == 16'd0, "R5 outputs", outLeft, 0);
    rstN = 1'b1;
    waitClk(2);

    // R6: unity code passes samples
    pushSample(1000, -2000);
    pushSample(32767, -32768);
    waitClk(3);

    // R1, R3: attenuation word, first bit D0
    sendWord(8'h7A);
    check(attCode == 7'h7A, "R1/R3 attCode", attCode, 122);
    check(emphMode == 2'd0, "R3 emphMode unchanged", emphMode, 0);
    pushSample(10000, -10000);
    pushSample(32767, -32768);
    pushSample(1, -1);          // R6: truncation toward zero gives 0
    waitClk(3);

    // R4: de-emphasis words, low bits ignored
    sendWord(8'hE0);
    check(emphMode == 2'd3, "R4 mode 32k", emphMode, 3);
    check(attCode == 7'h7A, "R4 attCode unchanged", attCode, 122);
    sendWord(8'hC0);
    check(emphMode == 2'd2, "R4 mode 48k", emphMode, 2);
    sendWord(8'hBF);
    check(emphMode == 2'd1, "R4 mode 44k1 low bits ignored", emphMode, 1);
    check(attCode == 7'h7A, "R4 attCode after 0xBF", attCode, 122);
    sendWord(8'h9F);
    check(emphMode == 2'd0, "R4 mode off", emphMode, 0);

    // R2: shifting with no latch rise changes nothing
    shiftBits(8'h11);
    waitClk(8);
    check(attCode == 7'h7A, "R2 no latch attCode", attCode, 122);
    check(emphMode == 2'd0, "R2 no latch emphMode", emphMode, 0);

    // R6: smallest non-zero code
    sendWord(8'h01);
    check(attCode == 7'h01, "R6 attCode 1", attCode, 1);
    pushSample(32767, -32768);
    waitClk(3);

    // R7: code zero mutes
    sendWord(8'h00);
    check(attCode == 7'h00, "R7 attCode 0", attCode, 0);
    pushSample(32767, -32768);
    pushSample(-5, 12345);
    waitClk(3);

    // R9: shift edges during latch high are ignored
    shiftBits(8'h20);
    latchPin = 1'b1;
    waitClk(8);
    expCode = 32;
    check(attCode == 7'h20, "R9 first apply", attCode, 32);
    shiftBits(8'h7F);
    latchPin = 1'b0;
    waitClk(8);
    pulseLatch();
    check(attCode == 7'h20, "R9 stale word reapplied", attCode, 32);

    // R10, R8: independent channels, back-to-back strobes
    sendWord(8'h40);
    pushSample(12700, -127);
    pushSample(-32768, 32767);
    pushSample(777, 0);
    waitClk(2);
    held = outLeft;
    waitClk(6);
    check(outLeft == held, "R8 hold left", outLeft, held);
    check(outValid == 1'b0, "R8 valid low", outValid, 0);

    check(expL.size() == 0, "R8 all samples produced", expL.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule